// File: doc/BRIEF.md
# Bidirectional Interrupt Line Router

This block joins seven prioritised backplane interrupt request lines (levels 1 to 7) to one interrupt line shared across a system interconnect. Every level carries an enable bit and a direction bit in a single configuration register. An enabled level either feeds the shared line outward or is driven from it inward. Several levels routed outward share the one line as a wired-OR.

A handler on the far side of the interconnect services an interrupt by reading the acknowledge register that belongs to the level it is handling. That read makes the block request a local interrupt-acknowledge cycle at that level from the local bus master. The 16-bit status/ID the master returns is handed back as the read data. If the level has no pending request, the read ends at once with an error response instead of waiting.

Request lines are modelled as active-high "assert" signals, with bit i standing for level i+1. The open-drain drivers themselves sit outside the block. The remote line is asynchronous to the block clock and is synchronised before it touches any local line.

Top module: `irq_level_router`

## Requirements
- R1: After hard reset the configuration register reads 0, and rem_irq_out, loc_irq_out and iack_req are all 0.
- R2: A level whose enable bit is 0 routes nothing in either direction, whatever its direction bit holds.
- R3: A level with enable 1 and direction 0 drives the remote line. rem_irq_out shows the OR of the qualifying loc_irq_in bits one clock after they are sampled.
- R4: When several levels are routed outward, rem_irq_out is the wired-OR of all of them.
- R5: A level with enable 1 and direction 1 copies rem_irq_in onto its loc_irq_out bit. A change on rem_irq_in appears on loc_irq_out on the third rising edge after it: two synchroniser flops, then the output register.
- R6: The configuration register sits at address 0. Bit 8+x is the enable of level x and bit x is its direction (x = 1..7). Bits 0 and 8 always read 0, and every other bit reads back as written.
- R7: soft_rst clears configuration bits 7:0 (the directions) and leaves bits 15:8 (the enables) unchanged. Hard reset clears both bytes.
- R8: A read of address x (x = 1..7) while loc_irq_in of level x is asserted raises iack_req with iack_level = x on the next cycle. iack_req is held until iack_ack is sampled. On the cycle after that, reg_ready pulses with reg_rdata = iack_id and reg_err = 0.
- R9: A read of an acknowledge address whose level has no pending request completes on the next cycle with reg_ready and reg_err both 1, and it raises no iack_req.
- R10: A read of an address above 7 completes with an error. A write to any address other than 0 also completes with an error and leaves the configuration unchanged.
- R11: Each access is answered by a single-cycle reg_ready pulse. Configuration reads and writes are answered on the cycle after the access is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset, synchronous, active high; clears the direction byte only |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_addr | input | 4 | Register address: 0 = configuration, 1..7 = acknowledge of that level |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid with reg_ready |
| reg_ready | output | 1 | Access complete, one-cycle pulse |
| reg_err | output | 1 | Access ended with an error, valid with reg_ready |
| loc_irq_in | input | 7 | Sensed local request lines, bit i = level i+1 |
| loc_irq_out | output | 7 | Local request drive, bit i = level i+1 |
| rem_irq_in | input | 1 | Sensed remote shared interrupt line (asynchronous) |
| rem_irq_out | output | 1 | Remote shared interrupt line drive |
| iack_req | output | 1 | Request to the local master for an interrupt-acknowledge cycle |
| iack_level | output | 3 | Level to be acknowledged |
| iack_ack | input | 1 | Local master finished the acknowledge cycle |
| iack_id | input | 16 | Status/ID returned by the acknowledge cycle |

## Verification
The assertions assume a well-behaved register initiator. It issues one-cycle strobes, never asserts reg_rd and reg_wr together, and starts no new access until the previous one has been answered. They also assume that the local master raises iack_ack only while iack_req is high, and that nobody writes the configuration in the same cycle as a soft reset. The stimulus honours all of this. Each access is issued by a task that waits for reg_ready before returning. The master is modelled inside the acknowledge task and answers only after it has seen the request. Soft reset is pulsed only between accesses. Random configurations, line patterns and acknowledge delays come from a seeded generator, and directed cases cover the byte-wise resets and the error paths.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic [0:0] {
    PORT_IDLE = 1'b0,
    PORT_IACK = 1'b1
  } port_state_e;

  typedef struct packed {
    logic ready;
    logic err;
  } port_resp_t;

  function automatic port_resp_t resp_ok();
    port_resp_t r;
    r.ready = 1'b1;
    r.err   = 1'b0;
    return r;
  endfunction

  function automatic port_resp_t resp_err();
    port_resp_t r;
    r.ready = 1'b1;
    r.err   = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
  parameter int NUM_LEVELS = 7,
  localparam int HALF  = NUM_LEVELS + 1,
  localparam int CFG_W = 2 * HALF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  soft_rst,
  input  logic                  wr_en,
  input  logic [CFG_W-1:0]      wdata,
  output logic [NUM_LEVELS-1:0] en_o,
  output logic [NUM_LEVELS-1:0] dir_o,
  output logic [CFG_W-1:0]      cfg_o
);

  logic [NUM_LEVELS-1:0] en_q;
  logic [NUM_LEVELS-1:0] dir_q;

  // Enable byte: hard reset only.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (wr_en) begin
      en_q <= wdata[HALF+1 +: NUM_LEVELS];
    end
  end

  // Direction byte: hard or soft reset.
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      dir_q <= '0;
    end else if (wr_en) begin
      dir_q <= wdata[1 +: NUM_LEVELS];
    end
  end

  assign en_o  = en_q;
  assign dir_o = dir_q;
  assign cfg_o = {en_q, 1'b0, dir_q, 1'b0};

endmodule

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/irq_route_fabric.sv
module irq_route_fabric #(
  parameter int NUM_LEVELS = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEVELS-1:0] en,
  input  logic [NUM_LEVELS-1:0] dir,
  input  logic [NUM_LEVELS-1:0] loc_in,
  input  logic                  rem_sync,
  output logic [NUM_LEVELS-1:0] loc_out,
  output logic                  rem_out
);

  logic [NUM_LEVELS-1:0] outward_hit;
  logic [NUM_LEVELS-1:0] inward_drv;

  generate
    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl
      assign outward_hit[i] = en[i] & ~dir[i] & loc_in[i];
      assign inward_drv[i]  = en[i] &  dir[i] & rem_sync;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_out <= 1'b0;
      loc_out <= '0;
    end else begin
      rem_out <= |outward_hit;
      loc_out <= inward_drv;
    end
  end

endmodule

// File: rtl/irq_ack_port.sv
module irq_ack_port
  import irq_router_pkg::*;
#(
  parameter int NUM_LEVELS = 7,
  parameter int ADDR_W     = 4,
  parameter int ID_W       = 16,
  localparam int LVL_W     = $clog2(NUM_LEVELS + 1),
  localparam int CFG_W     = 2 * (NUM_LEVELS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_rd,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [CFG_W-1:0]      cfg_rdata,
  input  logic [NUM_LEVELS-1:0] pending,
  input  logic                  iack_ack,
  input  logic [ID_W-1:0]       iack_id,
  output logic                  cfg_wr,
  output logic                  reg_ready,
  output logic                  reg_err,
  output logic [ID_W-1:0]       reg_rdata,
  output logic                  iack_req,
  output logic [LVL_W-1:0]      iack_level
);

  port_state_e state_q;
  port_resp_t  resp_q;
  logic        is_cfg;
  logic        is_ack;
  logic        pend_hit;
  logic        idle;

  assign idle   = (state_q == PORT_IDLE);
  assign is_cfg = (reg_addr == '0);

  always_comb begin
    is_ack   = 1'b0;
    pend_hit = 1'b0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (reg_addr == ADDR_W'(i + 1)) begin
        is_ack   = 1'b1;
        pend_hit = pending[i];
      end
    end
  end

  assign cfg_wr = idle & reg_wr & ~reg_rd & is_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PORT_IDLE;
      resp_q     <= '0;
      reg_rdata  <= '0;
      iack_req   <= 1'b0;
      iack_level <= '0;
    end else begin
      resp_q <= '0;
      unique case (state_q)
        PORT_IDLE: begin
          if (reg_rd) begin
            if (is_cfg) begin
              resp_q    <= resp_ok();
              reg_rdata <= ID_W'(cfg_rdata);
            end else if (is_ack && pend_hit) begin
              state_q    <= PORT_IACK;
              iack_req   <= 1'b1;
              iack_level <= LVL_W'(reg_addr);
            end else begin
              resp_q    <= resp_err();
              reg_rdata <= '0;
            end
          end else if (reg_wr) begin
            resp_q <= is_cfg ? resp_ok() : resp_err();
          end
        end
        PORT_IACK: begin
          if (iack_ack) begin
            state_q   <= PORT_IDLE;
            iack_req  <= 1'b0;
            resp_q    <= resp_ok();
            reg_rdata <= iack_id;
          end
        end
        default: state_q <= PORT_IDLE;
      endcase
    end
  end

  assign reg_ready = resp_q.ready;
  assign reg_err   = resp_q.err;

endmodule

// File: rtl/irq_level_router.sv
module irq_level_router #(
  parameter int NUM_LEVELS  = 7,
  parameter int ADDR_W      = 4,
  parameter int ID_W        = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(NUM_LEVELS + 1),
  localparam int CFG_W      = 2 * (NUM_LEVELS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  soft_rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [ID_W-1:0]       reg_wdata,
  output logic [ID_W-1:0]       reg_rdata,
  output logic                  reg_ready,
  output logic                  reg_err,
  input  logic [NUM_LEVELS-1:0] loc_irq_in,
  output logic [NUM_LEVELS-1:0] loc_irq_out,
  input  logic                  rem_irq_in,
  output logic                  rem_irq_out,
  output logic                  iack_req,
  output logic [LVL_W-1:0]      iack_level,
  input  logic                  iack_ack,
  input  logic [ID_W-1:0]       iack_id
);

  logic [NUM_LEVELS-1:0] cfg_en;
  logic [NUM_LEVELS-1:0] cfg_dir;
  logic [CFG_W-1:0]      cfg_word;
  logic                  cfg_wr;
  logic                  rem_sync;

  irq_cfg_reg #(.NUM_LEVELS(NUM_LEVELS)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .wr_en    (cfg_wr),
    .wdata    (CFG_W'(reg_wdata)),
    .en_o     (cfg_en),
    .dir_o    (cfg_dir),
    .cfg_o    (cfg_word)
  );

  irq_sync #(.STAGES(SYNC_STAGES), .W(1)) u_rem_sync (
    .clk (clk),
    .rst (rst),
    .d   (rem_irq_in),
    .q   (rem_sync)
  );

  irq_route_fabric #(.NUM_LEVELS(NUM_LEVELS)) u_fabric (
    .clk      (clk),
    .rst      (rst),
    .en       (cfg_en),
    .dir      (cfg_dir),
    .loc_in   (loc_irq_in),
    .rem_sync (rem_sync),
    .loc_out  (loc_irq_out),
    .rem_out  (rem_irq_out)
  );

  irq_ack_port #(
    .NUM_LEVELS (NUM_LEVELS),
    .ADDR_W     (ADDR_W),
    .ID_W       (ID_W)
  ) u_port (
    .clk        (clk),
    .rst        (rst),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .cfg_rdata  (cfg_word),
    .pending    (loc_irq_in),
    .iack_ack   (iack_ack),
    .iack_id    (iack_id),
    .cfg_wr     (cfg_wr),
    .reg_ready  (reg_ready),
    .reg_err    (reg_err),
    .reg_rdata  (reg_rdata),
    .iack_req   (iack_req),
    .iack_level (iack_level)
  );

endmodule

// File: rtl/irq_level_router_chk.sv
module irq_level_router_chk #(
  parameter int NUM_LEVELS = 7,
  parameter int ADDR_W     = 4,
  localparam int LVL_W     = $clog2(NUM_LEVELS + 1)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  soft_rst,
  input logic                  reg_wr,
  input logic                  reg_rd,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic                  reg_ready,
  input logic                  reg_err,
  input logic [NUM_LEVELS-1:0] loc_irq_in,
  input logic [NUM_LEVELS-1:0] loc_irq_out,
  input logic                  rem_irq_out,
  input logic                  iack_req,
  input logic [LVL_W-1:0]      iack_level,
  input logic                  iack_ack,
  input logic [NUM_LEVELS-1:0] cfg_en,
  input logic [NUM_LEVELS-1:0] cfg_dir
);

  logic ack_addr_idle_miss;

  always_comb begin
    ack_addr_idle_miss = 1'b0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (reg_addr == ADDR_W'(i + 1) && !loc_irq_in[i]) ack_addr_idle_miss = 1'b1;
    end
  end

  AST_OUTWARD_OR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rem_irq_out == $past(|(loc_irq_in & cfg_en & ~cfg_dir)))); // R4

  AST_INWARD_GATED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((loc_irq_out & ~$past(cfg_en & cfg_dir)) == '0)); // R2

  AST_IACK_HELD: assert property (@(posedge clk) disable iff (rst)
    (iack_req && !iack_ack) |=> (iack_req && $stable(iack_level))); // R8

  AST_IACK_DONE: assert property (@(posedge clk) disable iff (rst)
    (iack_req && iack_ack) |=> (reg_ready && !reg_err && !iack_req)); // R8

  AST_NO_PEND_ERR: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !iack_req && ack_addr_idle_miss) |=> (reg_ready && reg_err && !iack_req)); // R9

  AST_SOFT_LOW_CLR: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (cfg_dir == '0)); // R7

  AST_SOFT_KEEP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && !reg_wr) |=> $stable(cfg_en)); // R7

  AST_ERR_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    reg_err |-> reg_ready); // R11

endmodule

bind irq_level_router irq_level_router_chk #(
  .NUM_LEVELS (NUM_LEVELS),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .soft_rst    (soft_rst),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_ready   (reg_ready),
  .reg_err     (reg_err),
  .loc_irq_in  (loc_irq_in),
  .loc_irq_out (loc_irq_out),
  .rem_irq_out (rem_irq_out),
  .iack_req    (iack_req),
  .iack_level  (iack_level),
  .iack_ack    (iack_ack),
  .cfg_en      (cfg_en),
  .cfg_dir     (cfg_dir)
);

// File: tb/sim_irq_level_router.sv
module sim_irq_level_router;

  localparam int N = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        reg_ready;
  logic        reg_err;
  logic [N-1:0] loc_irq_in = '0;
  logic [N-1:0] loc_irq_out;
  logic        rem_irq_in = 1'b0;
  logic        rem_irq_out;
  logic        iack_req;
  logic [2:0]  iack_level;
  logic        iack_ack = 1'b0;
  logic [15:0] iack_id = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model of the configuration
  logic [15:0] m_cfg = '0;

  always #10ns clk = ~clk;

  irq_level_router u0 (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_ready(reg_ready), .reg_err(reg_err),
    .loc_irq_in(loc_irq_in), .loc_irq_out(loc_irq_out),
    .rem_irq_in(rem_irq_in), .rem_irq_out(rem_irq_out),
    .iack_req(iack_req), .iack_level(iack_level),
    .iack_ack(iack_ack), .iack_id(iack_id)
  );

  function automatic logic [15:0] cfg_mask(input logic [15:0] v);
    return v & 16'hFEFE;
  endfunction

  function automatic logic [N-1:0] m_en();
    return m_cfg[15:9];
  endfunction

  function automatic logic [N-1:0] m_dir();
    return m_cfg[7:1];
  endfunction

  function automatic logic exp_rem_out(input logic [N-1:0] loc);
    return |(loc & m_en() & ~m_dir());
  endfunction

  function automatic logic [N-1:0] exp_loc_out(input logic rem);
    return m_en() & m_dir() & {N{rem}};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [15:0] d, input bit exp_err,
                          input string req);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    check(reg_ready == 1'b1, req, "write ready", reg_ready, 1);
    check(reg_err == exp_err, req, "write err", reg_err, exp_err);
    if (!exp_err) m_cfg = cfg_mask(d);
    @(negedge clk);
    check(reg_ready == 1'b0, "R11", "ready pulse width", reg_ready, 0);
  endtask

  task automatic do_read(input logic [3:0] a, input bit exp_err, input logic [15:0] exp_d,
                         input string req);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(reg_ready == 1'b1, req, "read ready", reg_ready, 1);
    check(reg_err == exp_err, req, "read err", reg_err, exp_err);
    if (!exp_err) check(reg_rdata == exp_d, req, "read data", reg_rdata, exp_d);
    @(negedge clk);
  endtask

  task automatic do_ack(input int lvl, input int delay, input logic [15:0] id);
    bit pend;
    pend = loc_irq_in[lvl-1];
    reg_rd = 1'b1; reg_addr = 4'(lvl);
    @(negedge clk);
    reg_rd = 1'b0;
    if (!pend) begin
      check(reg_ready && reg_err, "R9", "no-pending ack error", {reg_ready, reg_err}, 2'b11);
      check(iack_req == 1'b0, "R9", "no iack_req", iack_req, 0);
      @(negedge clk);
    end else begin
      check(iack_req == 1'b1, "R8", "iack_req raised", iack_req, 1);
      check(iack_level == 3'(lvl), "R8", "iack_level", iack_level, lvl);
      check(reg_ready == 1'b0, "R8", "no early ready", reg_ready, 0);
      tick(delay);
      check(iack_req == 1'b1, "R8", "iack_req held", iack_req, 1);
      iack_ack = 1'b1; iack_id = id;
      @(negedge clk);
      iack_ack = 1'b0;
      check(reg_ready && !reg_err, "R8", "ack response", {reg_ready, reg_err}, 2'b10);
      check(reg_rdata == id, "R8", "status/ID", reg_rdata, id);
      check(iack_req == 1'b0, "R8", "iack_req dropped", iack_req, 0);
      @(negedge clk);
    end
  endtask

  task automatic check_routes(input string req);
    check(rem_irq_out == exp_rem_out(loc_irq_in), req, "rem_irq_out",
          rem_irq_out, exp_rem_out(loc_irq_in));
    check(loc_irq_out == exp_loc_out(rem_irq_in), req, "loc_irq_out",
          loc_irq_out, exp_loc_out(rem_irq_in));
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'h0001_2345);
    tick(4);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    check(rem_irq_out == 0 && loc_irq_out == 0 && iack_req == 0, "R1", "outputs after reset",
          {rem_irq_out, loc_irq_out, iack_req}, 0);
    do_read(4'd0, 1'b0, 16'h0000, "R1");

    // R6 layout
    do_write(4'd0, 16'hFFFF, 1'b0, "R6");
    do_read(4'd0, 1'b0, 16'hFEFE, "R6");
    do_write(4'd0, 16'h0402, 1'b0, "R6");
    do_read(4'd0, 1'b0, 16'h0402, "R6");

    // R7 soft reset clears directions only, hard clears all
    do_write(4'd0, 16'hFEFE, 1'b0, "R7");
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    m_cfg = 16'hFE00;
    do_read(4'd0, 1'b0, 16'hFE00, "R7");
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    m_cfg = 16'h0000;
    do_read(4'd0, 1'b0, 16'h0000, "R7");

    // R2 disabled levels with all directions set
    do_write(4'd0, 16'h00FE, 1'b0, "R2");
    loc_irq_in = '1; rem_irq_in = 1'b1;
    tick(3);
    check(rem_irq_out == 0, "R2", "disabled outward", rem_irq_out, 0);
    check(loc_irq_out == 0, "R2", "disabled inward", loc_irq_out, 0);
    loc_irq_in = '0; rem_irq_in = 1'b0;
    tick(3);

    // R3 single outward level 3
    do_write(4'd0, 16'h0800, 1'b0, "R3");
    loc_irq_in = 7'b0000100;
    @(negedge clk);
    check(rem_irq_out == 1, "R3", "level3 outward", rem_irq_out, 1);
    loc_irq_in = 7'b1111011;
    @(negedge clk);
    check(rem_irq_out == 0, "R3", "other levels ignored", rem_irq_out, 0);

    // R4 wired-OR of levels 1 and 5
    do_write(4'd0, 16'h2200, 1'b0, "R4");
    loc_irq_in = 7'b0010000;
    @(negedge clk);
    check(rem_irq_out == 1, "R4", "level5 only", rem_irq_out, 1);
    loc_irq_in = 7'b0000001;
    @(negedge clk);
    check(rem_irq_out == 1, "R4", "level1 only", rem_irq_out, 1);
    loc_irq_in = 7'b0010001;
    @(negedge clk);
    check(rem_irq_out == 1, "R4", "both levels", rem_irq_out, 1);
    loc_irq_in = 7'b1101110;
    @(negedge clk);
    check(rem_irq_out == 0, "R4", "neither level", rem_irq_out, 0);
    loc_irq_in = '0;

    // R5 inward levels 2 and 6, latency of three edges
    do_write(4'd0, 16'h4444, 1'b0, "R5");
    rem_irq_in = 1'b1;
    tick(2);
    check(loc_irq_out == 0, "R5", "not before third edge", loc_irq_out, 0);
    @(negedge clk);
    check(loc_irq_out == 7'b0100010, "R5", "on third edge", loc_irq_out, 7'b0100010);
    rem_irq_in = 1'b0;
    tick(3);
    check(loc_irq_out == 0, "R5", "release", loc_irq_out, 0);

    // R8 / R9 acknowledge
    loc_irq_in = 7'b0001000;
    do_ack(4, 5, 16'hBEEF);
    do_ack(6, 0, 16'h0000);
    do_ack(4, 0, 16'h1234);

    // R10 bad addresses
    do_read(4'd9, 1'b1, 16'h0, "R10");
    do_read(4'd15, 1'b1, 16'h0, "R10");
    do_write(4'd3, 16'hFFFF, 1'b1, "R10");
    do_read(4'd0, 1'b0, m_cfg, "R10");

    // Random phase
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom_range(0, 3));
      if (op == 0) begin
        do_write(4'd0, 16'($urandom), 1'b0, "R6");
        do_read(4'd0, 1'b0, m_cfg, "R6");
      end else if (op == 1) begin
        loc_irq_in = N'($urandom);
        rem_irq_in = 1'($urandom);
        tick(3);
        check_routes("R3");
      end else if (op == 2) begin
        loc_irq_in = N'($urandom);
        do_ack(int'($urandom_range(1, 7)), int'($urandom_range(0, 6)), 16'($urandom));
      end else begin
        soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
        m_cfg = m_cfg & 16'hFF00;
        do_read(4'd0, 1'b0, m_cfg, "R7");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule